// File: doc/BRIEF.md
# Shared Address Bus Request Arbiter

This block sits between a memory master and a set of DRAM bank slots. The master presents one request per cycle, made of an address, a transfer size and a write flag. Every request must cross a single shared address bus. The bus carries one request at a time and takes a fixed number of cycles to do so. A request that finds the bus occupied waits in a bounded first-in first-out buffer. When that buffer is full, the request is dropped and an error pulse is raised.

When a request comes off the bus, the block takes the bank index from a fixed bit field of its address. The request is then issued to that bank in the same cycle, unless one of three things holds: the bank reports itself busy, the chip that holds the bank is refreshing, or earlier requests for that bank are still waiting. In any of those cases the request joins a small per-bank queue. The queue drains as soon as the bank and its chip are both free. A full bank queue drops the request and raises a separate error pulse. Two counters report how many requests crossed the bus and how many had to wait for it.

Top module: `sab_arbiter`

## Requirements
- R1: After reset, no bank is issued a request, both error pulses are low, both counters read zero and the bus is idle, so the first request is accepted at once.
- R2: A request presented in cycle n to an idle bus is delivered in cycle n+BUS_LAT. Its bank index is address bits [BANK_LSB +: log2(NBANK)]. If that bank is free, `iss_valid[b]` is high in the delivery cycle, and lane b of `iss_addr`, `iss_size` and `iss_write` (lane b occupies bits b*width upward) carries the request.
- R3: A request arriving while the bus is busy waits in the bus FIFO. Waiting requests cross the bus in arrival order, and each is delivered BUS_LAT cycles after the previous delivery.
- R4: A request that arrives while the bus is busy, the bus FIFO is full and no delivery happens in that cycle is dropped, and `bus_ovf_err` is high in that same cycle.
- R5: When a delivery and an arrival fall in the same cycle, the FIFO head takes the bus first and the arrival is queued behind it. If the FIFO is empty, the arrival takes the bus directly and is delivered BUS_LAT cycles later without counting as a wait.
- R6: A request delivered to a bank whose `bank_busy` bit is high, or whose chip (index bank / BANKS_PER_CHIP) has its `chip_refresh` bit high, is held. It is issued in the first cycle in which both bits are low.
- R7: Requests for one bank are issued in delivery order. A delivery to a bank that still holds queued requests joins the queue and is not issued ahead of them.
- R8: A request delivered to a bank whose queue is full and not draining in that cycle is dropped, and `bank_ovf_err` is high in that delivery cycle.
- R9: Refresh on one chip does not hold requests for banks on other chips.
- R10: `xfer_count` rises by one for every delivery off the bus, including deliveries dropped at a full bank queue. `wait_count` rises by one for every request placed in the bus FIFO. A request dropped at the bus counts in neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Physical address |
| req_size | input | SIZE_W | Transfer size |
| req_write | input | 1 | 1 = write, 0 = read |
| bank_busy | input | NBANK | Per-bank busy level |
| chip_refresh | input | NBANK/BANKS_PER_CHIP | Per-chip refresh-in-progress level |
| iss_valid | output | NBANK | Request issued to bank this cycle |
| iss_addr | output | NBANK*ADDR_W | Per-bank issued address lanes |
| iss_size | output | NBANK*SIZE_W | Per-bank issued size lanes |
| iss_write | output | NBANK | Per-bank issued write flag |
| bus_ovf_err | output | 1 | Bus FIFO overflow, request dropped |
| bank_ovf_err | output | 1 | Bank queue overflow, request dropped |
| xfer_count | output | CNT_W | Bus deliveries so far |
| wait_count | output | CNT_W | Requests that waited for the bus |

## Verification
The assertions place no condition on how `bank_busy` relates to an issue. A bank may stay free after one request and accept the next one straight away. The bench therefore drives the busy and refresh bits only as held levels that it changes at chosen cycles. The assertions do assume that `bank_busy` and `chip_refresh` stay stable between clock edges, since issue is combinational from them. The bench changes every input shortly after the rising edge and samples outputs mid-cycle. The overflow properties also assume that the master does not look at the error pulses before it issues the next request. The stimulus sends each burst without regard to them.

// File: rtl/sab_pkg.sv
package sab_pkg;
  localparam int ADDR_W = 32;
  localparam int SIZE_W = 8;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [SIZE_W-1:0] size;
    logic              wr;
  } sab_req_t;

  localparam int REQ_W = $bits(sab_req_t);

  // bank index: field of width log2(nbank) starting at bit lsb (nbank a power of two)
  function automatic logic [31:0] bank_of(input logic [ADDR_W-1:0] a,
                                          input int unsigned lsb,
                                          input int unsigned nbank);
    logic [ADDR_W-1:0] s;
    s = (a >> lsb) & ADDR_W'(nbank - 1);
    return 32'(s);
  endfunction

  function automatic int unsigned chip_of(input int unsigned bank,
                                          input int unsigned per_chip);
    return bank / per_chip;
  endfunction
endpackage

// File: rtl/sab_fifo.sv
module sab_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] fill;
  logic          do_pop, do_push;

  assign empty   = (fill == '0);
  assign full    = (fill == CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign dout    = mem[rd_ptr];

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_ptr <= wrap_inc(wr_ptr);
      if (do_pop)  rd_ptr <= wrap_inc(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/sab_bus.sv
module sab_bus
  import sab_pkg::*;
#(
  parameter int LAT        = 3,
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  sab_req_t         in_req,
  output logic             dlv,
  output sab_req_t         dlv_req,
  output logic             ovf,
  output logic [CNT_W-1:0] xfer_cnt,
  output logic [CNT_W-1:0] wait_cnt
);
  localparam int LW = (LAT > 1) ? $clog2(LAT) : 1;

  logic          busy;
  logic [LW-1:0] left;
  sab_req_t      cur;

  logic     f_push, f_pop, f_full, f_empty, take_direct, push_ok;
  logic [REQ_W-1:0] f_dout;
  sab_req_t f_head;

  assign f_head      = f_dout;
  assign dlv         = busy && (left == '0);
  assign dlv_req     = cur;
  assign f_pop       = dlv && !f_empty;
  assign take_direct = in_vld && f_empty && (!busy || dlv);
  assign f_push      = in_vld && !take_direct;
  assign push_ok     = f_push && (!f_full || f_pop);
  assign ovf         = f_push && !push_ok;

  sab_fifo #(.W(REQ_W), .DEPTH(FIFO_DEPTH)) u_wait_fifo (
    .clk(clk), .rst_n(rst_n), .push(f_push), .pop(f_pop),
    .din(in_req), .dout(f_dout), .full(f_full), .empty(f_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      left <= '0;
      cur  <= '0;
    end else if (f_pop) begin
      cur  <= f_head;
      left <= LW'(LAT - 1);
      busy <= 1'b1;
    end else if (take_direct) begin
      cur  <= in_req;
      left <= LW'(LAT - 1);
      busy <= 1'b1;
    end else if (dlv) begin
      busy <= 1'b0;
    end else if (busy) begin
      left <= left - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xfer_cnt <= '0;
      wait_cnt <= '0;
    end else begin
      if (dlv)     xfer_cnt <= xfer_cnt + 1'b1;
      if (push_ok) wait_cnt <= wait_cnt + 1'b1;
    end
  end

  AST_IDLE_BUS_EMPTY_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> f_empty); // R5
  AST_DROP_LEAVES_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> f_full); // R4
  AST_DELIVERY_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv && (LAT > 1)) |=> !dlv); // R3
  AST_XFER_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    dlv |=> (xfer_cnt == $past(xfer_cnt) + 1'b1)); // R10
endmodule

// File: rtl/sab_slot.sv
module sab_slot
  import sab_pkg::*;
#(
  parameter int Q_DEPTH = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     dlv_hit,
  input  sab_req_t dlv_req,
  input  logic     blocked,
  output logic     iss_vld,
  output sab_req_t iss_req,
  output logic     ovf
);
  logic q_push, q_pop, q_full, q_empty, drain, direct;
  logic [REQ_W-1:0] q_dout;
  sab_req_t q_head;

  assign q_head  = q_dout;
  assign drain   = !q_empty && !blocked;
  assign direct  = dlv_hit && q_empty && !blocked;
  assign q_push  = dlv_hit && !direct;
  assign q_pop   = drain;
  assign ovf     = q_push && q_full && !q_pop;
  assign iss_vld = drain || direct;
  assign iss_req = drain ? q_head : dlv_req;

  sab_fifo #(.W(REQ_W), .DEPTH(Q_DEPTH)) u_bank_q (
    .clk(clk), .rst_n(rst_n), .push(q_push), .pop(q_pop),
    .din(dlv_req), .dout(q_dout), .full(q_full), .empty(q_empty)
  );

  AST_NO_ISSUE_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    iss_vld |-> !blocked); // R6
  AST_BLOCKED_KEEPS_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && !q_empty) |=> !q_empty); // R6
  AST_BANK_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> q_full); // R8
endmodule

// File: rtl/sab_arbiter.sv
module sab_arbiter
  import sab_pkg::*;
#(
  parameter int NBANK          = 4,
  parameter int BANKS_PER_CHIP = 2,
  parameter int BANK_LSB       = 6,
  parameter int BUS_LAT        = 3,
  parameter int BUS_FIFO_DEPTH = 4,
  parameter int BANK_Q_DEPTH   = 2,
  parameter int CNT_W          = 16,
  localparam int NCHIP         = NBANK / BANKS_PER_CHIP
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [SIZE_W-1:0]         req_size,
  input  logic                      req_write,
  input  logic [NBANK-1:0]          bank_busy,
  input  logic [NCHIP-1:0]          chip_refresh,
  output logic [NBANK-1:0]          iss_valid,
  output logic [NBANK*ADDR_W-1:0]   iss_addr,
  output logic [NBANK*SIZE_W-1:0]   iss_size,
  output logic [NBANK-1:0]          iss_write,
  output logic                      bus_ovf_err,
  output logic                      bank_ovf_err,
  output logic [CNT_W-1:0]          xfer_count,
  output logic [CNT_W-1:0]          wait_count
);
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1;

  sab_req_t         in_req, dlv_req;
  logic             dlv;
  logic [BW-1:0]    dlv_bank;
  logic [NBANK-1:0] dlv_hit, slot_ovf;
  sab_req_t         slot_req [NBANK];

  assign in_req = '{addr: req_addr, size: req_size, wr: req_write};

  sab_bus #(.LAT(BUS_LAT), .FIFO_DEPTH(BUS_FIFO_DEPTH), .CNT_W(CNT_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .in_vld(req_valid), .in_req(in_req),
    .dlv(dlv), .dlv_req(dlv_req), .ovf(bus_ovf_err),
    .xfer_cnt(xfer_count), .wait_cnt(wait_count)
  );

  assign dlv_bank = BW'(bank_of(dlv_req.addr, BANK_LSB, NBANK));

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int CHIP = chip_of(b, BANKS_PER_CHIP);
    assign dlv_hit[b] = dlv && (dlv_bank == BW'(b));

    sab_slot #(.Q_DEPTH(BANK_Q_DEPTH)) u_slot (
      .clk(clk), .rst_n(rst_n), .dlv_hit(dlv_hit[b]), .dlv_req(dlv_req),
      .blocked(bank_busy[b] || chip_refresh[CHIP]),
      .iss_vld(iss_valid[b]), .iss_req(slot_req[b]), .ovf(slot_ovf[b])
    );

    assign iss_addr[b*ADDR_W +: ADDR_W] = slot_req[b].addr;
    assign iss_size[b*SIZE_W +: SIZE_W] = slot_req[b].size;
    assign iss_write[b]                 = slot_req[b].wr;
  end

  assign bank_ovf_err = |slot_ovf;

  AST_SINGLE_DELIVERY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dlv_hit)); // R2
  AST_DELIVERY_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    dlv |-> (dlv_hit != '0)); // R2
endmodule

// File: tb/test_sab_arbiter.sv
module test_sab_arbiter;
  localparam int NB = 4;
  localparam int AW = 32;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [SW-1:0] req_size = '0;
  logic req_write = 1'b0;
  logic [NB-1:0] bank_busy = '0;
  logic [1:0] chip_refresh = '0;
  logic [NB-1:0] iss_valid, iss_write;
  logic [NB*AW-1:0] iss_addr;
  logic [NB*SW-1:0] iss_size;
  logic bus_ovf_err, bank_ovf_err;
  logic [15:0] xfer_count, wait_count;

  int checks = 0;
  int errors = 0;
  int exp_x = 0;
  int exp_w = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sab_arbiter #(.BUS_LAT(4), .BUS_FIFO_DEPTH(2), .BANK_Q_DEPTH(2)) i_sab_arbiter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .bank_busy(bank_busy),
    .chip_refresh(chip_refresh), .iss_valid(iss_valid), .iss_addr(iss_addr),
    .iss_size(iss_size), .iss_write(iss_write), .bus_ovf_err(bus_ovf_err),
    .bank_ovf_err(bank_ovf_err), .xfer_count(xfer_count), .wait_count(wait_count)
  );

  function automatic logic [AW-1:0] mk(input int bank, input int row);
    return AW'((row << 8) | ((bank & 3) << 6) | (row & 63));
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(posedge clk);
    #2;
    req_valid = 1'b0;
  endtask

  task automatic cyc();
    nxt();
    #10;
  endtask

  task automatic cyc_send(input logic [AW-1:0] a, input int s, input bit w);
    nxt();
    req_valid = 1'b1;
    req_addr  = a;
    req_size  = SW'(s);
    req_write = w;
    #10;
  endtask

  task automatic expect_iss(input int b, input logic [AW-1:0] a, input int s,
                            input bit w, input string req);
    chk(iss_valid == NB'(1 << b), req, iss_valid, 1 << b);
    chk(iss_addr[b*AW +: AW] == a && iss_size[b*SW +: SW] == SW'(s) && iss_write[b] == w,
        req, iss_addr[b*AW +: AW], a);
  endtask

  task automatic expect_none(input string req);
    chk(iss_valid == '0, req, iss_valid, 0);
  endtask

  task automatic check_counts(input string req);
    cyc();
    chk(xfer_count == 16'(exp_x), req, xfer_count, exp_x);
    chk(wait_count == 16'(exp_w), req, wait_count, exp_w);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #10;
    expect_none("R1");
    chk(!bus_ovf_err && !bank_ovf_err, "R1", {bus_ovf_err, bank_ovf_err}, 0);
    chk(xfer_count == '0 && wait_count == '0, "R1", xfer_count, 0);
  endtask

  task automatic t_single();
    cyc_send(mk(2, 5), 8, 1'b0);
    expect_none("R2");
    repeat (3) cyc();
    expect_none("R2 early");
    cyc();
    expect_iss(2, mk(2, 5), 8, 1'b0, "R1 R2");
    exp_x += 1;
    check_counts("R10");
  endtask

  task automatic t_fifo_order();
    cyc_send(mk(0, 1), 4, 1'b1);
    cyc_send(mk(1, 2), 16, 1'b0);
    repeat (2) cyc();
    cyc(); expect_iss(0, mk(0, 1), 4, 1'b1, "R3 first");
    repeat (2) cyc();
    cyc(); expect_none("R3 spacing");
    cyc(); expect_iss(1, mk(1, 2), 16, 1'b0, "R3 second");
    exp_x += 2; exp_w += 1;
    check_counts("R10 R3");
  endtask

  task automatic t_bus_ovf();
    cyc_send(mk(0, 3), 1, 1'b0);
    cyc_send(mk(1, 4), 2, 1'b0);
    cyc_send(mk(2, 5), 3, 1'b0);
    chk(!bus_ovf_err, "R4 not yet", bus_ovf_err, 0);
    cyc_send(mk(3, 6), 4, 1'b0);
    chk(bus_ovf_err, "R4 overflow", bus_ovf_err, 1);
    cyc(); expect_iss(0, mk(0, 3), 1, 1'b0, "R4 head");
    chk(!bus_ovf_err, "R4 pulse", bus_ovf_err, 0);
    repeat (3) cyc();
    cyc(); expect_iss(1, mk(1, 4), 2, 1'b0, "R4 B");
    repeat (3) cyc();
    cyc(); expect_iss(2, mk(2, 5), 3, 1'b0, "R4 C");
    repeat (3) cyc();
    cyc(); expect_none("R4 dropped");
    exp_x += 3; exp_w += 2;
    check_counts("R10 R4");
  endtask

  task automatic t_same_cycle();
    cyc_send(mk(1, 7), 5, 1'b0);
    cyc_send(mk(2, 8), 6, 1'b1);
    repeat (2) cyc();
    cyc_send(mk(3, 9), 7, 1'b0);
    expect_iss(1, mk(1, 7), 5, 1'b0, "R5 A");
    repeat (3) cyc();
    cyc(); expect_iss(2, mk(2, 8), 6, 1'b1, "R5 head first");
    repeat (3) cyc();
    cyc(); expect_iss(3, mk(3, 9), 7, 1'b0, "R5 arrival after");
    exp_x += 3; exp_w += 2;
    check_counts("R10 R5");
    cyc_send(mk(0, 10), 9, 1'b0);
    repeat (3) cyc();
    cyc_send(mk(1, 11), 10, 1'b1);
    expect_iss(0, mk(0, 10), 9, 1'b0, "R5 direct A");
    repeat (3) cyc();
    cyc(); expect_iss(1, mk(1, 11), 10, 1'b1, "R5 direct take");
    exp_x += 2;
    check_counts("R10 R5 no wait");
  endtask

  task automatic t_bank_busy();
    nxt(); bank_busy[1] = 1'b1; #10;
    cyc_send(mk(1, 12), 11, 1'b0);
    repeat (3) cyc();
    cyc(); expect_none("R6 held busy");
    cyc(); expect_none("R6 still held");
    nxt(); bank_busy[1] = 1'b0; #10;
    expect_iss(1, mk(1, 12), 11, 1'b0, "R6 release");
    cyc(); expect_none("R6 once");
    exp_x += 1;
    check_counts("R10 R6");
  endtask

  task automatic t_refresh();
    nxt(); chip_refresh[0] = 1'b1; #10;
    cyc_send(mk(0, 13), 12, 1'b1);
    cyc_send(mk(2, 14), 13, 1'b0);
    repeat (2) cyc();
    cyc(); expect_none("R6 refresh holds");
    repeat (3) cyc();
    cyc(); expect_iss(2, mk(2, 14), 13, 1'b0, "R9 other chip");
    nxt(); chip_refresh[0] = 1'b0; #10;
    expect_iss(0, mk(0, 13), 12, 1'b1, "R6 refresh end");
    exp_x += 2; exp_w += 1;
    check_counts("R10 R9");
  endtask

  task automatic t_bank_order();
    nxt(); bank_busy[3] = 1'b1; #10;
    cyc_send(mk(3, 15), 14, 1'b0);
    cyc_send(mk(3, 16), 15, 1'b1);
    repeat (2) cyc();
    cyc(); expect_none("R7 first queued");
    repeat (3) cyc();
    nxt(); bank_busy[3] = 1'b0; #10;
    expect_iss(3, mk(3, 15), 14, 1'b0, "R7 older first");
    cyc(); expect_iss(3, mk(3, 16), 15, 1'b1, "R7 newer second");
    cyc(); expect_none("R7 drained");
    exp_x += 2; exp_w += 1;
    check_counts("R10 R7");
  endtask

  task automatic t_bank_ovf();
    nxt(); bank_busy[2] = 1'b1; #10;
    cyc_send(mk(2, 17), 16, 1'b0);
    cyc_send(mk(2, 18), 17, 1'b0);
    cyc_send(mk(2, 19), 18, 1'b0);
    repeat (5) cyc();
    cyc(); chk(!bank_ovf_err, "R8 room", bank_ovf_err, 0);
    repeat (3) cyc();
    cyc(); chk(bank_ovf_err, "R8 overflow", bank_ovf_err, 1);
    nxt(); bank_busy[2] = 1'b0; #10;
    expect_iss(2, mk(2, 17), 16, 1'b0, "R8 kept P");
    cyc(); expect_iss(2, mk(2, 18), 17, 1'b0, "R8 kept Q");
    cyc(); expect_none("R8 dropped");
    exp_x += 3; exp_w += 2;
    check_counts("R10 R8");
  endtask

  initial begin
    t_reset();
    t_single();
    t_fifo_order();
    t_bus_ovf();
    t_same_cycle();
    t_bank_busy();
    t_refresh();
    t_bank_order();
    t_bank_ovf();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule